// File: doc/BRIEF.md
# Debug Port Power Sequencer

This block brings the power domains of a debug port up before the port carries traffic, and takes them down again when the port is released. It talks to the debug port's own registers through a simple master interface that carries one request at a time: a request strobe with address, write enable and write data, and an acknowledge with read data. A start pulse runs the power-up sequence and a stop pulse runs the power-down sequence. A protocol flag, sampled when start is accepted, selects the JTAG or SWD flavour of the final clean-up writes.

On start, the block selects register bank 0 and reads the control/status register. If both power acknowledge bits are already set, it finishes at once. Otherwise it requests debug and system power, then polls until the port acknowledges. Next it requests a debug reset and polls for that acknowledge. Last, it sets the transfer mode and byte lanes and clears the sticky error flags. A free-running microsecond tick drives two poll timeouts. Only the power acknowledge timeout is fatal. The debug reset timeout lets the sequence go on, because a debug reset line that is not wired must not block the port. Completion is signalled by a one-cycle done pulse, with an error level beside it.

Top module: `dbg_pwr_ctrl`

## Requirements
- R1: An accepted start first writes 0x0 to the bank select register (address 0x8), then reads the control/status register (address 0x4).
- R2: If that first status read has both bits 31 and 29 set (mask 0xA0000000), the block pulses done_o with error_o low and issues no further request.
- R3: Otherwise it writes 0x50000000 to address 0x4, then keeps reading address 0x4 until a read shows both bits of mask 0xA0000000 set.
- R4: If PWR_TO_US ticks pass during the power poll without that acknowledge, the block raises error_o together with a done_o pulse after the pending read, and issues no further request.
- R5: After the power acknowledge it writes 0x54000000 to address 0x4, then keeps reading address 0x4 until a read shows all bits of mask 0xA8000000 set.
- R6: If RST_TO_US ticks pass during the debug reset poll, the sequence goes on to its final writes and error_o stays low.
- R7: With jtag_i high at start, the final access is a write of 0x50000F32 to address 0x4, followed by done_o.
- R8: With jtag_i low at start, the block writes 0x50000F00 to address 0x4 and then 0x1E to the abort register (address 0x0), followed by done_o.
- R9: An accepted stop writes 0x0 to address 0x8, then 0x0 to address 0x4, then pulses done_o with error_o low.
- R10: At most one request is outstanding. dp_req_o, dp_addr_o, dp_we_o and dp_wdata_o hold steady until dp_ack_i, and dp_req_o is low in the cycle after the acknowledge.
- R11: start_i and stop_i are ignored while a sequence runs. A change of jtag_i during a sequence has no effect.
- R12: done_o lasts one cycle. error_o rises only together with done_o and clears when the next command is accepted.
- R13: After reset, dp_req_o, done_o and error_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Power-up command pulse |
| stop_i | input | 1 | Power-down command pulse |
| jtag_i | input | 1 | Protocol select, 1 = JTAG, 0 = SWD |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| dp_req_o | output | 1 | Register access request |
| dp_we_o | output | 1 | Access is a write |
| dp_addr_o | output | 4 | Debug port register address |
| dp_wdata_o | output | 32 | Write data |
| dp_ack_i | input | 1 | Access acknowledge |
| dp_rdata_i | input | 32 | Read data, valid with dp_ack_i |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| error_o | output | 1 | Power acknowledge timed out |

## Verification
On every cycle the assertions check the request discipline: a request and its address and data hold until acknowledged, the request drops after the acknowledge, and nothing is requested once done is signalled. They also check that done lasts one cycle and that the error flag can rise only with done. Only the bench scenarios can show the order and values of the register accesses on each path: already powered, slow acknowledge, fatal and non-fatal timeouts, the two protocol endings and power-down. The same holds for commands ignored mid-sequence and for the error flag clearing on the next command.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  parameter int unsigned DPC_AW = 4;
  parameter int unsigned DPC_DW = 32;

  localparam logic [DPC_AW-1:0] ADR_ABORT  = DPC_AW'(4'h0);
  localparam logic [DPC_AW-1:0] ADR_STAT   = DPC_AW'(4'h4);
  localparam logic [DPC_AW-1:0] ADR_SELECT = DPC_AW'(4'h8);

  localparam logic [DPC_DW-1:0] VAL_PWR_REQ   = 32'h5000_0000;
  localparam logic [DPC_DW-1:0] VAL_RST_REQ   = 32'h5400_0000;
  localparam logic [DPC_DW-1:0] VAL_JTAG_INIT = 32'h5000_0F32;
  localparam logic [DPC_DW-1:0] VAL_SWD_INIT  = 32'h5000_0F00;
  localparam logic [DPC_DW-1:0] VAL_ABORT_CLR = 32'h0000_001E;
  localparam logic [DPC_DW-1:0] MSK_PWR_ACK   = 32'hA000_0000;
  localparam logic [DPC_DW-1:0] MSK_RST_ACK   = 32'hA800_0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_CHK,
    ST_PWR_REQ,
    ST_PWR_POLL,
    ST_RST_REQ,
    ST_RST_POLL,
    ST_XFER,
    ST_ABORT,
    ST_STOP_SEL,
    ST_STOP_CTL
  } seq_st_e;

  typedef struct packed {
    logic              we;
    logic [DPC_AW-1:0] addr;
    logic [DPC_DW-1:0] wdata;
  } dp_cmd_t;
endpackage

// File: rtl/dpc_timer.sv
module dpc_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/dpc_req.sv
module dpc_req
  import dpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_v_i,
  input  dp_cmd_t           cmd_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DPC_AW-1:0] addr_o,
  output logic [DPC_DW-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DPC_DW-1:0] rdata_i,
  output logic              rsp_v_o,
  output logic [DPC_DW-1:0] rsp_data_o
);
  logic    pend_q;
  dp_cmd_t cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      cmd_q      <= '0;
      rsp_v_o    <= 1'b0;
      rsp_data_o <= '0;
    end else begin
      rsp_v_o <= 1'b0;
      if (pend_q && ack_i) begin
        pend_q     <= 1'b0;
        rsp_v_o    <= 1'b1;
        rsp_data_o <= rdata_i;
      end else if (!pend_q && cmd_v_i) begin
        pend_q <= 1'b1;
        cmd_q  <= cmd_i;
      end
    end
  end

  assign req_o   = pend_q;
  assign we_o    = cmd_q.we;
  assign addr_o  = cmd_q.addr;
  assign wdata_o = cmd_q.wdata;
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int unsigned PWR_TO_US = 1_000_000,
  parameter int unsigned RST_TO_US = 300_000,
  parameter int unsigned CNT_W     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              jtag_i,
  input  logic              rsp_v_i,
  input  logic [DPC_DW-1:0] rsp_data_i,
  input  logic              tmr_exp_i,
  output logic              cmd_v_o,
  output dp_cmd_t           cmd_o,
  output logic              tmr_clr_o,
  output logic [CNT_W-1:0]  tmr_lim_o,
  output logic              done_o,
  output logic              error_o
);
  seq_st_e st_q;
  logic    issued_q;
  logic    jtag_q;
  logic    pwr_ok, rst_ok;

  assign pwr_ok = (rsp_data_i & MSK_PWR_ACK) == MSK_PWR_ACK;
  assign rst_ok = (rsp_data_i & MSK_RST_ACK) == MSK_RST_ACK;

  always_comb begin
    cmd_o = '{we: 1'b0, addr: ADR_STAT, wdata: '0};
    unique case (st_q)
      ST_SEL, ST_STOP_SEL: cmd_o = '{we: 1'b1, addr: ADR_SELECT, wdata: '0};
      ST_PWR_REQ:          cmd_o = '{we: 1'b1, addr: ADR_STAT, wdata: VAL_PWR_REQ};
      ST_RST_REQ:          cmd_o = '{we: 1'b1, addr: ADR_STAT, wdata: VAL_RST_REQ};
      ST_XFER:             cmd_o = '{we: 1'b1, addr: ADR_STAT,
                                     wdata: jtag_q ? VAL_JTAG_INIT : VAL_SWD_INIT};
      ST_ABORT:            cmd_o = '{we: 1'b1, addr: ADR_ABORT, wdata: VAL_ABORT_CLR};
      ST_STOP_CTL:         cmd_o = '{we: 1'b1, addr: ADR_STAT, wdata: '0};
      default:             ;
    endcase
  end

  assign cmd_v_o   = (st_q != ST_IDLE) && !issued_q;
  assign tmr_clr_o = !(st_q == ST_PWR_POLL || st_q == ST_RST_POLL);
  assign tmr_lim_o = (st_q == ST_RST_POLL) ? CNT_W'(RST_TO_US) : CNT_W'(PWR_TO_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      jtag_q   <= 1'b0;
      done_o   <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q    <= ST_SEL;
          jtag_q  <= jtag_i;
          error_o <= 1'b0;
        end else if (stop_i) begin
          st_q    <= ST_STOP_SEL;
          error_o <= 1'b0;
        end
      end else if (!issued_q) begin
        issued_q <= 1'b1;
      end else if (rsp_v_i) begin
        issued_q <= 1'b0;
        unique case (st_q)
          ST_SEL:      st_q <= ST_CHK;
          ST_CHK:      if (pwr_ok) begin st_q <= ST_IDLE; done_o <= 1'b1; end
                       else st_q <= ST_PWR_REQ;
          ST_PWR_REQ:  st_q <= ST_PWR_POLL;
          ST_PWR_POLL: if (pwr_ok) st_q <= ST_RST_REQ;
                       else if (tmr_exp_i) begin
                         st_q    <= ST_IDLE;
                         done_o  <= 1'b1;
                         error_o <= 1'b1;
                       end
          ST_RST_REQ:  st_q <= ST_RST_POLL;
          ST_RST_POLL: if (rst_ok || tmr_exp_i) st_q <= ST_XFER;
          ST_XFER:     if (jtag_q) begin st_q <= ST_IDLE; done_o <= 1'b1; end
                       else st_q <= ST_ABORT;
          ST_ABORT:    begin st_q <= ST_IDLE; done_o <= 1'b1; end
          ST_STOP_SEL: st_q <= ST_STOP_CTL;
          ST_STOP_CTL: begin st_q <= ST_IDLE; done_o <= 1'b1; end
          default:     st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_pwr_ctrl.sv
module dbg_pwr_ctrl
  import dpc_pkg::*;
#(
  parameter int unsigned PWR_TO_US = 1_000_000,
  parameter int unsigned RST_TO_US = 300_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              jtag_i,
  input  logic              tick_i,
  output logic              dp_req_o,
  output logic              dp_we_o,
  output logic [DPC_AW-1:0] dp_addr_o,
  output logic [DPC_DW-1:0] dp_wdata_o,
  input  logic              dp_ack_i,
  input  logic [DPC_DW-1:0] dp_rdata_i,
  output logic              done_o,
  output logic              error_o
);
  localparam int unsigned MAX_TO = (PWR_TO_US > RST_TO_US) ? PWR_TO_US : RST_TO_US;
  localparam int unsigned CNT_W  = $clog2(MAX_TO + 1);

  logic              cmd_v, rsp_v, tmr_clr, tmr_exp;
  dp_cmd_t           cmd;
  logic [DPC_DW-1:0] rsp_data;
  logic [CNT_W-1:0]  tmr_lim;

  dpc_seq #(
    .PWR_TO_US(PWR_TO_US),
    .RST_TO_US(RST_TO_US),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .jtag_i    (jtag_i),
    .rsp_v_i   (rsp_v),
    .rsp_data_i(rsp_data),
    .tmr_exp_i (tmr_exp),
    .cmd_v_o   (cmd_v),
    .cmd_o     (cmd),
    .tmr_clr_o (tmr_clr),
    .tmr_lim_o (tmr_lim),
    .done_o    (done_o),
    .error_o   (error_o)
  );

  dpc_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_v_i   (cmd_v),
    .cmd_i     (cmd),
    .req_o     (dp_req_o),
    .we_o      (dp_we_o),
    .addr_o    (dp_addr_o),
    .wdata_o   (dp_wdata_o),
    .ack_i     (dp_ack_i),
    .rdata_i   (dp_rdata_i),
    .rsp_v_o   (rsp_v),
    .rsp_data_o(rsp_data)
  );

  dpc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .tick_i   (tick_i),
    .limit_i  (tmr_lim),
    .expired_o(tmr_exp)
  );
endmodule

// File: rtl/dbg_pwr_ctrl_chk.sv
module dbg_pwr_ctrl_chk
  import dpc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dp_req_o,
  input logic              dp_we_o,
  input logic [DPC_AW-1:0] dp_addr_o,
  input logic [DPC_DW-1:0] dp_wdata_o,
  input logic              dp_ack_i,
  input logic              done_o,
  input logic              error_o
);
  a_r10_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_req_o && !dp_ack_i |=> dp_req_o && $stable(dp_addr_o) && $stable(dp_we_o)
                              && $stable(dp_wdata_o));

  a_r10_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_req_o && dp_ack_i |=> !dp_req_o);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);

  a_r4_quiet_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dp_req_o);
endmodule

bind dbg_pwr_ctrl dbg_pwr_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dp_req_o  (dp_req_o),
  .dp_we_o   (dp_we_o),
  .dp_addr_o (dp_addr_o),
  .dp_wdata_o(dp_wdata_o),
  .dp_ack_i  (dp_ack_i),
  .done_o    (done_o),
  .error_o   (error_o)
);

// File: tb/tb_dbg_pwr_ctrl.sv
module tb_dbg_pwr_ctrl;
  localparam int unsigned PWR_TO = 40;
  localparam int unsigned RST_TO = 20;
  localparam int NEVER = 1_000_000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, jtag_i = 1'b0, tick_i = 1'b0;
  logic        dp_req_o, dp_we_o, dp_ack_i = 1'b0;
  logic [3:0]  dp_addr_o;
  logic [31:0] dp_wdata_o, dp_rdata_i = '0;
  logic        done_o, error_o;

  int n_chk = 0, n_fail = 0;
  int n_log = 0;
  logic        lg_we[256];
  logic [3:0]  lg_addr[256];
  logic [31:0] lg_data[256];
  int   stat_mode = 0, rd_cnt = 0, pwr_fail = 0, rst_fail = 0, lat = 0, wait_cnt = 0;
  logic init_up = 1'b0;
  int   hold_err = 0;
  logic        seen = 1'b0;
  logic [31:0] seen_w;
  logic [3:0]  seen_a;
  logic        seen_we;
  logic        last_err = 1'b0;

  dbg_pwr_ctrl #(.PWR_TO_US(PWR_TO), .RST_TO_US(RST_TO)) dut (.*);

  always #10 clk_i = ~clk_i;

  initial forever begin
    repeat (3) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  end

  function automatic logic [31:0] stat_val();
    case (stat_mode)
      0:       return init_up ? 32'hA000_0000 : 32'h0;
      1:       return (rd_cnt < pwr_fail) ? 32'h2000_0000 : 32'hA000_0000;
      default: return (rd_cnt < rst_fail) ? 32'hA000_0000 : 32'hA800_0000;
    endcase
  endfunction

  // Register-port responder with configurable latency
  initial forever begin
    @(negedge clk_i);
    if (dp_ack_i) begin
      dp_ack_i = 1'b0;
      seen = 1'b0;
    end else if (dp_req_o) begin
      if (!seen) begin
        seen = 1'b1; seen_a = dp_addr_o; seen_w = dp_wdata_o; seen_we = dp_we_o;
      end else if (seen_a !== dp_addr_o || seen_w !== dp_wdata_o || seen_we !== dp_we_o)
        hold_err++;
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        dp_ack_i = 1'b1;
        lg_we[n_log] = dp_we_o; lg_addr[n_log] = dp_addr_o;
        if (dp_we_o) begin
          dp_rdata_i = '0;
          lg_data[n_log] = dp_wdata_o;
          if (dp_addr_o == 4'h4 && dp_wdata_o == 32'h5000_0000 && stat_mode == 0) begin
            stat_mode = 1; rd_cnt = 0;
          end else if (dp_addr_o == 4'h4 && dp_wdata_o == 32'h5400_0000) begin
            stat_mode = 2; rd_cnt = 0;
          end
        end else begin
          dp_rdata_i = (dp_addr_o == 4'h4) ? stat_val() : 32'h0;
          if (dp_addr_o == 4'h4 && stat_mode != 0) rd_cnt++;
          lg_data[n_log] = dp_rdata_i;
        end
        if (n_log < 255) n_log++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_wr(string tag, int i, logic [3:0] a, logic [31:0] d);
    chk({tag, " we"}, 32'(lg_we[i]), 32'd1);
    chk({tag, " addr"}, 32'(lg_addr[i]), 32'(a));
    chk({tag, " data"}, lg_data[i], d);
  endtask

  task automatic chk_rd(string tag, int i);
    chk({tag, " rd"}, {27'd0, lg_we[i], lg_addr[i]}, 32'h4);
  endtask

  task automatic prep(logic up, int pf, int rf, int l);
    n_log = 0; stat_mode = 0; rd_cnt = 0;
    init_up = up; pwr_fail = pf; rst_fail = rf; lat = l;
  endtask

  task automatic go(logic st, logic jt);
    @(negedge clk_i);
    start_i = st; stop_i = !st; jtag_i = jt;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int cyc = 0;
    while (!done_o && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
    end
    chk({tag, " done seen"}, 32'(done_o), 32'd1);
    last_err = error_o;
    @(negedge clk_i);
    chk({tag, " done one cycle"}, 32'(done_o), 32'd0);
    repeat (10) @(negedge clk_i);
    chk({tag, " idle after done"}, 32'(dp_req_o), 32'd0);
  endtask

  task automatic t_reset();
    chk("R13 req", 32'(dp_req_o), 32'd0);
    chk("R13 done", 32'(done_o), 32'd0);
    chk("R13 error", 32'(error_o), 32'd0);
  endtask

  task automatic t_powered();
    prep(1'b1, 0, 0, 0);
    go(1'b1, 1'b1);
    wait_done("R2");
    chk("R2 count", n_log, 2);
    chk_wr("R1 select", 0, 4'h8, 32'h0);
    chk_rd("R1 status", 1);
    chk("R2 error", 32'(last_err), 32'd0);
  endtask

  task automatic t_jtag_slow();
    prep(1'b0, 2, 1, 0);
    go(1'b1, 1'b1);
    repeat (4) @(negedge clk_i);
    // R11: commands and flag change mid-sequence
    start_i = 1'b1; stop_i = 1'b1; jtag_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    wait_done("R7");
    chk("R11 count", n_log, 10);
    chk_wr("R1 select", 0, 4'h8, 32'h0);
    chk_rd("R1 status", 1);
    chk_wr("R3 pwr req", 2, 4'h4, 32'h5000_0000);
    for (int i = 3; i < 6; i++) chk_rd("R3 poll", i);
    chk_wr("R5 rst req", 6, 4'h4, 32'h5400_0000);
    chk_rd("R5 poll", 7);
    chk_rd("R5 poll", 8);
    chk_wr("R7 final", 9, 4'h4, 32'h5000_0F32);
    chk("R7 error", 32'(last_err), 32'd0);
  endtask

  task automatic t_swd();
    prep(1'b0, 0, 0, 2);
    go(1'b1, 1'b0);
    wait_done("R8");
    chk("R8 count", n_log, 8);
    chk_wr("R3 pwr req", 2, 4'h4, 32'h5000_0000);
    chk_wr("R5 rst req", 4, 4'h4, 32'h5400_0000);
    chk_wr("R8 ctrl", 6, 4'h4, 32'h5000_0F00);
    chk_wr("R8 abort", 7, 4'h0, 32'h0000_001E);
    chk("R10 hold while waiting", hold_err, 0);
    chk("R8 error", 32'(last_err), 32'd0);
  endtask

  task automatic t_pwr_timeout();
    int bad = 0;
    prep(1'b0, NEVER, 0, 1);
    go(1'b1, 1'b1);
    wait_done("R4");
    chk("R4 error", 32'(last_err), 32'd1);
    chk("R4 error held", 32'(error_o), 32'd1);
    chk("R4 polled", 32'(n_log > 4), 32'd1);
    chk_rd("R4 last is poll", n_log - 1);
    for (int i = 0; i < n_log; i++)
      if (lg_we[i] && lg_data[i] == 32'h5400_0000) bad++;
    chk("R4 no rst req", bad, 0);
  endtask

  task automatic t_clear_by_start();
    prep(1'b1, 0, 0, 0);
    go(1'b1, 1'b0);
    wait_done("R12");
    chk("R12 error cleared", 32'(last_err), 32'd0);
  endtask

  task automatic t_rst_timeout();
    prep(1'b0, 0, NEVER, 0);
    go(1'b1, 1'b1);
    wait_done("R6");
    chk("R6 error", 32'(last_err), 32'd0);
    chk("R6 polled", 32'(n_log > 8), 32'd1);
    chk_wr("R6 final", n_log - 1, 4'h4, 32'h5000_0F32);
  endtask

  task automatic t_stop();
    prep(1'b0, NEVER, 0, 0);
    go(1'b1, 1'b0);
    wait_done("R9 pre");
    chk("R9 pre error", 32'(last_err), 32'd1);
    prep(1'b0, 0, 0, 1);
    go(1'b0, 1'b0);
    wait_done("R9");
    chk("R9 count", n_log, 2);
    chk_wr("R9 select", 0, 4'h8, 32'h0);
    chk_wr("R9 ctrl", 1, 4'h4, 32'h0);
    chk("R9 R12 error cleared", 32'(last_err), 32'd0);
    chk("R10 hold", hold_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_powered();
    t_jtag_slow();
    t_swd();
    t_pwr_timeout();
    t_clear_by_start();
    t_rst_timeout();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule